// File: doc/BRIEF.md
# Ramp-compare ADC conversion sequencer

This block runs a single-slope conversion built from one digital output, an external RC network and one comparator per channel. It toggles a ramp-control output to charge and then discharge the RC network. Each edge of that output opens a measurement window. A TDC block, referenced to the ramp edge, reports when each channel's comparator switches as a bin code, and that code is the raw sample. Every ramp edge yields one sample per channel. The rising edge produces the leading samples and the falling edge produces the trailing ones.

A short RC constant gives an exponential voltage-to-time curve. A lookup table therefore turns each raw code into a linear code that is two bits wider. The table is built at elaboration by a function and read synchronously, so it maps onto block RAM. A channel that does not switch inside its window reports a saturated code with an overflow flag. While a window is open, a quiet output is held high so that noisy neighbouring logic, such as a microprocessor, can be held in a wait state. A mode input chooses between a high-resolution mode (HI_BITS-bit codes, long window) and a fast mode (LO_BITS-bit codes, short window).

Top module: `adc_ramp_seq`

## Requirements
- R1: While `rst` is high, and for as long as `enable` stays low afterwards, `ramp_out`, `quiet` and `out_vld` are all 0.
- R2: Once `enable` is high, the conversions repeat. `ramp_out` rises, which opens a leading window, and stays high through that window and the drain after it. It then falls, which opens a trailing window. Each change of `ramp_out` happens in the same cycle that `quiet` rises.
- R3: `quiet` is high for exactly the window length: WIN_HI cycles in high-resolution mode or WIN_LO cycles in fast mode. It is low at all other times.
- R4: A channel's sample is the code from the first `hit_vld` pulse that is sampled while `quiet` is 1. Later pulses in the same window are ignored, and so are pulses sampled while `quiet` is 0.
- R5: A channel with no accepted hit reports `out_ovf`=1 and `out_code` all ones (2^(HI_BITS+2)-1).
- R6: In fast mode, any code with a nonzero bit at position LO_BITS or above is reported as overflow, as in R5.
- R7: Without overflow, for raw code t and b = HI_BITS (or LO_BITS in fast mode), `out_code` = (t*(3*2^b-1-t)) >> (b-1). The result is never above 4*(2^HI_BITS-1).
- R8: After each window the block emits NCH samples on consecutive cycles, for channels 0 to NCH-1 in order. `out_trail` is 0 for samples from the rising edge and 1 for samples from the falling edge.
- R9: `mode_fast` (1 = fast) is sampled only when a leading window starts. That value applies to the leading and the trailing window of the same conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run conversions; checked when a conversion ends |
| mode_fast | input | 1 | 1 = fast mode, 0 = high-resolution mode |
| hit_vld | input | NCH | Per-channel comparator transition strobe from the TDC |
| hit_code | input | NCH*HI_BITS | Per-channel TDC bin code, channel c at bits c*HI_BITS upward |
| ramp_out | output | 1 | Drive to the RC network |
| quiet | output | 1 | High while a window is open |
| out_vld | output | 1 | Sample strobe |
| out_ch | output | clog2(NCH) | Sample channel index |
| out_trail | output | 1 | 1 when the sample comes from the falling ramp |
| out_ovf | output | 1 | No valid transition in the window |
| out_code | output | HI_BITS+2 | Linearized sample code |

## Verification
Some properties hold on every cycle and are checked that way. These are: each change of the ramp output lines up with the start of a window, the quiet interval never runs longer than the long window, an overflowed sample carries the all-ones code, the code stays in range, and channel indices rise by one within each output burst. Other behaviour can only be shown by the bench scenarios, because it depends on when stimulus arrives relative to the windows. This includes the first-hit rule, hits just after a window closes being ignored, overflow in fast mode, the exact lookup values, the exact window lengths, and a mode change that waits for the next conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_DRAIN_L,
    ST_TRAIL,
    ST_DRAIN_T
  } seq_state_t;

  // Concave correction curve: maps a bin count on an exponential ramp
  // to a linear scale two bits wider than the input.
  function automatic int lin_map(input int t, input int bits);
    int f;
    f = 1 << bits;
    return (t * (3 * f - 1 - t)) >>> (bits - 1);
  endfunction

endpackage

// File: rtl/adc_ramp_ctrl.sv
module adc_ramp_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int WIN_HI = 24,
  parameter int WIN_LO = 10,
  parameter int CH_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            mode_fast,
  output logic            ramp_out,
  output logic            quiet,
  output logic            fast_q,
  output logic            clr,
  output logic            rd_en,
  output logic [CH_W-1:0] rd_sel,
  output logic            rd_trail
);
  localparam int WIN_MAX = (WIN_HI > WIN_LO) ? ((WIN_HI > NCH) ? WIN_HI : NCH)
                                             : ((WIN_LO > NCH) ? WIN_LO : NCH);
  localparam int CNT_W   = $clog2(WIN_MAX + 1);

  seq_state_t       st, nxt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] win_last;
  logic             in_win_nxt;

  assign win_last = fast_q ? CNT_W'(WIN_LO - 1) : CNT_W'(WIN_HI - 1);

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:    if (enable) nxt = ST_LEAD;
      ST_LEAD:    if (cnt == win_last) nxt = ST_DRAIN_L;
      ST_DRAIN_L: if (cnt == CNT_W'(NCH - 1)) nxt = ST_TRAIL;
      ST_TRAIL:   if (cnt == win_last) nxt = ST_DRAIN_T;
      ST_DRAIN_T: if (cnt == CNT_W'(NCH - 1)) nxt = enable ? ST_LEAD : ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  assign in_win_nxt = (nxt == ST_LEAD) || (nxt == ST_TRAIL);
  assign clr        = in_win_nxt && (nxt != st);
  assign rd_en      = (st == ST_DRAIN_L) || (st == ST_DRAIN_T);
  assign rd_sel     = cnt[CH_W-1:0];
  assign rd_trail   = (st == ST_DRAIN_T);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      fast_q   <= 1'b0;
      ramp_out <= 1'b0;
      quiet    <= 1'b0;
    end else begin
      st       <= nxt;
      cnt      <= (nxt != st) ? '0 : cnt + 1'b1;
      if (nxt == ST_LEAD && st != ST_LEAD) fast_q <= mode_fast;
      ramp_out <= (nxt == ST_LEAD) || (nxt == ST_DRAIN_L);
      quiet    <= in_win_nxt;
    end
  end

endmodule

// File: rtl/adc_hit_capture.sv
module adc_hit_capture #(
  parameter int NCH     = 4,
  parameter int HI_BITS = 9,
  parameter int LO_BITS = 6,
  parameter int CH_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   win_open,
  input  logic                   fast,
  input  logic [NCH-1:0]         hit_vld,
  input  logic [NCH*HI_BITS-1:0] hit_code,
  input  logic                   rd_en,
  input  logic [CH_W-1:0]        rd_sel,
  input  logic                   rd_trail,
  output logic                   s1_vld,
  output logic [CH_W-1:0]        s1_ch,
  output logic                   s1_trail,
  output logic                   s1_ovf,
  output logic                   s1_fast,
  output logic [HI_BITS-1:0]     s1_raw
);
  localparam logic [HI_BITS-1:0] LO_MASK = HI_BITS'((1 << LO_BITS) - 1);

  logic [NCH-1:0]     got;
  logic [HI_BITS-1:0] cap [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic               got_r;
    logic [HI_BITS-1:0] cap_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        got_r <= 1'b0;
        cap_r <= '0;
      end else if (clr) begin
        got_r <= 1'b0;
      end else if (win_open && hit_vld[c] && !got_r) begin
        got_r <= 1'b1;
        cap_r <= hit_code[c*HI_BITS +: HI_BITS];
      end
    end
    assign got[c] = got_r;
    assign cap[c] = cap_r;
  end

  logic [HI_BITS-1:0] sel_code;
  logic               sel_got;
  logic               hi_nz;

  assign sel_code = cap[rd_sel];
  assign sel_got  = got[rd_sel];
  assign hi_nz    = fast && ((sel_code & ~LO_MASK) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_ch    <= '0;
      s1_trail <= 1'b0;
      s1_ovf   <= 1'b0;
      s1_fast  <= 1'b0;
      s1_raw   <= '0;
    end else begin
      s1_vld   <= rd_en;
      s1_ch    <= rd_sel;
      s1_trail <= rd_trail;
      s1_ovf   <= !sel_got || hi_nz;
      s1_fast  <= fast;
      s1_raw   <= fast ? (sel_code & LO_MASK) : sel_code;
    end
  end

endmodule

// File: rtl/adc_lin_rom.sv
module adc_lin_rom
  import adc_seq_pkg::*;
#(
  parameter int BITS  = 9,
  parameter int OUT_W = 11
) (
  input  logic             clk,
  input  logic [BITS-1:0]  addr,
  output logic [OUT_W-1:0] dout
);
  localparam int DEPTH = 1 << BITS;

  logic [OUT_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = OUT_W'(lin_map(i, BITS));
  end

  always_ff @(posedge clk) dout <= mem[addr];

endmodule

// File: rtl/adc_ramp_seq.sv
module adc_ramp_seq #(
  parameter int NCH     = 4,
  parameter int HI_BITS = 9,
  parameter int LO_BITS = 6,
  parameter int WIN_HI  = 24,
  parameter int WIN_LO  = 10,
  parameter bit USE_LIN = 1'b1,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int OUT_W  = HI_BITS + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enable,
  input  logic                   mode_fast,
  input  logic [NCH-1:0]         hit_vld,
  input  logic [NCH*HI_BITS-1:0] hit_code,
  output logic                   ramp_out,
  output logic                   quiet,
  output logic                   out_vld,
  output logic [CH_W-1:0]        out_ch,
  output logic                   out_trail,
  output logic                   out_ovf,
  output logic [OUT_W-1:0]       out_code
);
  logic            fast_q, clr, rd_en, rd_trail;
  logic [CH_W-1:0] rd_sel;

  adc_ramp_ctrl #(.NCH(NCH), .WIN_HI(WIN_HI), .WIN_LO(WIN_LO), .CH_W(CH_W)) ctrl_i (
    .clk(clk), .rst(rst), .enable(enable), .mode_fast(mode_fast),
    .ramp_out(ramp_out), .quiet(quiet), .fast_q(fast_q), .clr(clr),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_trail(rd_trail)
  );

  logic               s1_vld, s1_trail, s1_ovf, s1_fast;
  logic [CH_W-1:0]    s1_ch;
  logic [HI_BITS-1:0] s1_raw;

  adc_hit_capture #(.NCH(NCH), .HI_BITS(HI_BITS), .LO_BITS(LO_BITS), .CH_W(CH_W)) cap_i (
    .clk(clk), .rst(rst), .clr(clr), .win_open(quiet), .fast(fast_q),
    .hit_vld(hit_vld), .hit_code(hit_code),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_trail(rd_trail),
    .s1_vld(s1_vld), .s1_ch(s1_ch), .s1_trail(s1_trail), .s1_ovf(s1_ovf),
    .s1_fast(s1_fast), .s1_raw(s1_raw)
  );

  // Stage 2: metadata waits alongside the synchronous table read.
  logic               s2_vld, s2_trail, s2_ovf, s2_fast;
  logic [CH_W-1:0]    s2_ch;
  logic [HI_BITS-1:0] s2_raw;
  logic [OUT_W-1:0]   lin_hi, lin_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld   <= 1'b0;
      s2_ch    <= '0;
      s2_trail <= 1'b0;
      s2_ovf   <= 1'b0;
      s2_fast  <= 1'b0;
      s2_raw   <= '0;
    end else begin
      s2_vld   <= s1_vld;
      s2_ch    <= s1_ch;
      s2_trail <= s1_trail;
      s2_ovf   <= s1_ovf;
      s2_fast  <= s1_fast;
      s2_raw   <= s1_raw;
    end
  end

  if (USE_LIN) begin : g_lin
    adc_lin_rom #(.BITS(HI_BITS), .OUT_W(OUT_W)) rom_hi_i (
      .clk(clk), .addr(s1_raw), .dout(lin_hi)
    );
    adc_lin_rom #(.BITS(LO_BITS), .OUT_W(OUT_W)) rom_lo_i (
      .clk(clk), .addr(s1_raw[LO_BITS-1:0]), .dout(lin_lo)
    );
  end else begin : g_raw
    assign lin_hi = {2'b00, s2_raw};
    assign lin_lo = {2'b00, s2_raw};
  end

  // Stage 3: registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_ch    <= '0;
      out_trail <= 1'b0;
      out_ovf   <= 1'b0;
      out_code  <= '0;
    end else begin
      out_vld   <= s2_vld;
      out_ch    <= s2_ch;
      out_trail <= s2_trail;
      out_ovf   <= s2_ovf;
      out_code  <= s2_ovf ? '1 : (s2_fast ? lin_lo : lin_hi);
    end
  end

endmodule

// File: rtl/adc_ramp_seq_chk.sv
module adc_ramp_seq_chk #(
  parameter int NCH     = 4,
  parameter int HI_BITS = 9,
  parameter int WIN_HI  = 24,
  parameter int WIN_LO  = 10,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int OUT_W  = HI_BITS + 2,
  localparam int LIN_MAX = 4 * ((1 << HI_BITS) - 1),
  localparam int WIN_MAX = (WIN_HI > WIN_LO) ? WIN_HI : WIN_LO
) (
  input logic             clk,
  input logic             rst,
  input logic             quiet,
  input logic             ramp_out,
  input logic             out_vld,
  input logic [CH_W-1:0]  out_ch,
  input logic             out_ovf,
  input logic [OUT_W-1:0] out_code
);
  logic [$clog2(WIN_MAX + 2)-1:0] qrun;

  always_ff @(posedge clk) begin
    if (rst) qrun <= '0;
    else if (quiet) qrun <= qrun + 1'b1;
    else qrun <= '0;
  end

  a_r3_quiet_max: assert property (@(posedge clk) disable iff (rst)
    int'(qrun) <= WIN_MAX);

  a_r2_ramp_edge_opens: assert property (@(posedge clk) disable iff (rst)
    !$stable(ramp_out) |-> $rose(quiet));

  a_r2_ramp_holds_at_close: assert property (@(posedge clk) disable iff (rst)
    $fell(quiet) |-> $stable(ramp_out));

  a_r5_ovf_code: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_ovf) |-> (out_code == '1));

  a_r7_range: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_ovf) |-> (int'(out_code) <= LIN_MAX));

  a_r8_ch_range: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (int'(out_ch) < NCH));

  a_r8_ch_order: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(out_vld)) |->
      ((int'(out_ch) == int'($past(out_ch)) + 1) || (out_ch == '0)));

endmodule

bind adc_ramp_seq adc_ramp_seq_chk #(
  .NCH(NCH), .HI_BITS(HI_BITS), .WIN_HI(WIN_HI), .WIN_LO(WIN_LO)
) chk_i (
  .clk(clk), .rst(rst), .quiet(quiet), .ramp_out(ramp_out),
  .out_vld(out_vld), .out_ch(out_ch), .out_ovf(out_ovf), .out_code(out_code)
);

// File: tb/adc_ramp_seq_tb_top.sv
`timescale 1ns/1ps
module adc_ramp_seq_tb_top;
  localparam int NCH = 4, HI = 9, LO = 6, WHI = 24, WLO = 10;
  localparam int CHW = 2, OW = HI + 2;
  localparam int FULL = (1 << OW) - 1;

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0, mode_fast = 1'b0;
  logic [NCH-1:0]    hit_vld = '0;
  logic [NCH*HI-1:0] hit_code = '0;
  logic ramp_out, quiet, out_vld, out_trail, out_ovf;
  logic [CHW-1:0] out_ch;
  logic [OW-1:0]  out_code;

  always #2.5 clk = ~clk;

  adc_ramp_seq #(.NCH(NCH), .HI_BITS(HI), .LO_BITS(LO), .WIN_HI(WHI), .WIN_LO(WLO)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .mode_fast(mode_fast),
    .hit_vld(hit_vld), .hit_code(hit_code), .ramp_out(ramp_out), .quiet(quiet),
    .out_vld(out_vld), .out_ch(out_ch), .out_trail(out_trail), .out_ovf(out_ovf),
    .out_code(out_code)
  );

  typedef struct { int ch; bit trail; int code; bit ovf; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  int w_code[NCH];
  bit w_fire[NCH];
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ref_lin(input int t, input int b);
    return (t * (3 * (1 << b) - 1 - t)) / (1 << (b - 1));
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Driver: follows one window, drives hits and pushes expectations.
  task automatic do_window(input bit is_trail, input bit fast, input bit late_noise,
                           input int mode_at);
    int j;
    @(negedge clk);
    while (!quiet) @(negedge clk);
    check(ramp_out == !is_trail, "R2 ramp level at window open", int'(ramp_out), int'(!is_trail));
    for (int c = 0; c < NCH; c++) begin
      exp_t e;
      e.ch = c; e.trail = is_trail;
      if (w_fire[c] && (!fast || w_code[c] < (1 << LO))) begin
        e.ovf = 1'b0; e.code = ref_lin(w_code[c], fast ? LO : HI);
      end else begin
        e.ovf = 1'b1; e.code = FULL;
      end
      exp_q.push_back(e);
    end
    j = 0;
    while (quiet) begin
      for (int c = 0; c < NCH; c++) begin
        hit_vld[c] = w_fire[c] && (j == c + 1 || j == c + 3);  // R4 second pulse ignored
        hit_code[c*HI +: HI] = (j == c + 1) ? HI'(w_code[c]) : HI'(w_code[c] ^ 21);
      end
      if (mode_at >= 0 && j == 2) mode_fast = mode_at[0];
      j++;
      @(negedge clk);
    end
    hit_vld = '0;
    check(j == (fast ? WLO : WHI), "R3 quiet window length", j, fast ? WLO : WHI);
    if (late_noise) begin  // R4: hits just after close must be ignored
      for (int c = 0; c < NCH; c++) begin
        hit_vld[c] = !w_fire[c];
        hit_code[c*HI +: HI] = HI'(3);
      end
      @(negedge clk);
      hit_vld = '0;
    end
  endtask

  task automatic set_win(input int c0, input int c1, input int c2, input int c3, input bit [3:0] f);
    w_code[0] = c0; w_code[1] = c1; w_code[2] = c2; w_code[3] = c3;
    for (int c = 0; c < NCH; c++) w_fire[c] = f[c];
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_vld && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected sample", int'(out_ch), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(out_ch) == e.ch, "R8 channel order", int'(out_ch), e.ch);
        check(out_trail == e.trail, "R8 leading/trailing tag", int'(out_trail), int'(e.trail));
        check(out_ovf == e.ovf, e.ovf ? "R5/R6 overflow flag" : "R4 overflow flag",
              int'(out_ovf), int'(e.ovf));
        check(int'(out_code) == e.code, e.ovf ? "R5 saturated code" : "R7 linear code",
              int'(out_code), e.code);
      end
    end
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    bit idle_ok;
    repeat (5) @(negedge clk);
    check(ramp_out == 1'b0, "R1 ramp_out in reset", int'(ramp_out), 0);
    check(quiet == 1'b0, "R1 quiet in reset", int'(quiet), 0);
    check(out_vld == 1'b0, "R1 out_vld in reset", int'(out_vld), 0);
    rst = 1'b0;
    idle_ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ramp_out || quiet || out_vld) idle_ok = 1'b0;
    end
    check(idle_ok, "R1 idle with enable low", int'(idle_ok), 1);

    enable = 1'b1;
    // Conversion 1, high resolution
    set_win(0, 100, 511, 257, 4'b1111); do_window(1'b0, 1'b0, 1'b0, -1);
    set_win(2, 480, 33, 0, 4'b0111);    do_window(1'b1, 1'b0, 1'b0, -1);
    // Conversion 2: missing hits, late noise, mode switched mid-window (R9)
    set_win(44, 0, 200, 0, 4'b0101);    do_window(1'b0, 1'b0, 1'b1, 1);
    set_win(0, 0, 0, 0, 4'b0000);       do_window(1'b1, 1'b0, 1'b1, -1);
    // Conversion 3, fast mode with out-of-range codes (R6)
    set_win(5, 63, 64, 300, 4'b1111);   do_window(1'b0, 1'b1, 1'b0, -1);
    set_win(0, 31, 62, 1, 4'b1111);     do_window(1'b1, 1'b1, 1'b0, -1);
    // Conversion 4, fast; mode returns to high resolution for the next one
    set_win(10, 20, 30, 40, 4'b1111);   do_window(1'b0, 1'b1, 1'b0, 0);
    set_win(63, 0, 7, 100, 4'b1101);    do_window(1'b1, 1'b1, 1'b1, -1);
    // Conversion 5, high resolution, then stop
    set_win(256, 1, 2, 3, 4'b1111);     do_window(1'b0, 1'b0, 1'b0, -1);
    enable = 1'b0;
    set_win(508, 509, 510, 511, 4'b1111); do_window(1'b1, 1'b0, 1'b0, -1);

    repeat (12) @(negedge clk);
    idle_ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ramp_out || quiet) idle_ok = 1'b0;
    end
    check(idle_ok, "R1 stays idle after enable drops", int'(idle_ok), 1);
    check(exp_q.size() == 0, "R8 all samples delivered", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end

endmodule